// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches one active-low external interrupt line and turns activity on it into an interrupt request for a CPU. The line is synchronized into the clock domain, and a high-to-low transition is caught in a request latch. Software picks one of two trigger modes. In edge mode, any acknowledge clears the latch at once. In level mode, the request is held for as long as the line stays low, and it is released only when both an acknowledge and the line's return to high have occurred, in either order.

An acknowledge comes either as a vector-fetch strobe from the CPU or as a write of one to an acknowledge bit. A mask bit gates the request output. It does not hide the pending flag, so software can poll for requests. The same status/control byte also exposes the synchronized line level. A second byte holds a bit that turns off the line's internal pull-up, and that bit drives a control output. The block also presents a fixed vector address: the high byte of the service routine address is stored at that address and the low byte at the next one.

Top module: `pinIrqCtrl`

## Requirements
- R1: While reset is asserted, and right after it, the request latch, mask, mode and pull-up-disable bits are all zero. `irqReq` and `pullUpDis` are low, and both register bytes read 0x00.
- R2: A high-to-low change on `pinN` sets the pending flag and, when unmasked, `irqReq`. This takes effect at the third rising clock edge after the change and not earlier.
- R3: With mode = 0, a `vecAck` pulse or a write of one to the acknowledge bit clears the latch at the next rising edge. It stays clear while `pinN` remains low.
- R4: With mode = 1, the latch stays set while the synchronized line is low, even after an acknowledge. It clears once an acknowledge has occurred and the synchronized line is high, in either order. When the acknowledge comes first, the latch clears at the third rising edge after `pinN` rises.
- R5: If a detected falling edge and an acknowledge occur in the same cycle, the latch stays set.
- R6: A falling edge that follows an acknowledge sets the latch again.
- R7: `irqReq` is high exactly when the latch is set and the mask bit is zero. The pending flag shows the latch whatever the mask holds.
- R8: The acknowledge bit always reads zero, and writing zero to it leaves the latch unchanged.
- R9: Register layout. At address 0 the status/control byte has: bit 0 mode (read/write), bit 1 mask (read/write), bit 2 acknowledge (write-only), bit 3 pending flag (read-only), bit 4 synchronized line level (read-only), and bits 7..5 reading zero. At address 1, bit 0 is pull-up disable (read/write) and the other bits read zero. Writes to read-only bits are ignored.
- R10: `pullUpDis` follows the configuration bit. Its default is 0, which means the pull-up is enabled.
- R11: `pinLevel`, and status bit 4, show `pinN` two rising edges after it changes.
- R12: `vecAddr` is 0xFFFA. The service routine address is stored high byte at 0xFFFA and low byte at 0xFFFB.
- R13: Reset clears the latch and the mode bit even when `pinN` is held low through and after reset. A line that is already low at release raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinN | input | 1 | Asynchronous active-low interrupt line |
| regAddr | input | ADDR_W | Register select (0 status/control, 1 config) |
| regWrEn | input | 1 | Write strobe for one cycle |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Combinational read data for `regAddr` |
| vecAck | input | 1 | Vector-fetch acknowledge pulse from the CPU |
| irqReq | output | 1 | Interrupt request to the CPU |
| pinLevel | output | 1 | Synchronized line level |
| pullUpDis | output | 1 | High turns off the line pull-up |
| vecAddr | output | 16 | Address of the vector high byte |

## Verification
Each result has a fixed arrival cycle. A line change reaches `pinLevel` at the second rising edge and the latch at the third. An acknowledge clears the latch at the first edge. In level mode, a line return after an acknowledge clears the latch at the third edge. Register writes land at the next edge, and reads are combinational. The bench drives inputs on falling edges and samples on falling edges after exactly that many rising edges. Where the timing is stated, it also checks the cycle before, so an early or late result is reported.

// File: rtl/pinIrqPkg.sv
package pinIrqPkg;
  // bit positions in the status/control byte (address 0)
  localparam int unsigned MODE_BIT  = 0;
  localparam int unsigned MASK_BIT  = 1;
  localparam int unsigned ACK_BIT   = 2;
  localparam int unsigned FLAG_BIT  = 3;
  localparam int unsigned LEVEL_BIT = 4;
  // bit position in the config byte (address 1)
  localparam int unsigned PULL_BIT  = 0;
  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned CFG_ADDR  = 1;

  typedef struct packed {
    logic latchSet;
    logic latchClr;
    logic holdSet;
    logic holdClr;
    logic wrCtrl;
    logic wrCfg;
  } pinIrqStrobes_t;
endpackage

// File: rtl/pinIrqControl.sv
module pinIrqControl
  import pinIrqPkg::*;
#(
  parameter int ADDR_W = 1
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              ackWrBit,
  input  logic              vecAck,
  input  logic              fallEdge,
  input  logic              pinSync,
  input  logic              modeBit,
  input  logic              ackHeld,
  output pinIrqStrobes_t    strobe
);
  logic wrCtrl;
  logic wrCfg;
  logic ackPulse;

  assign wrCtrl   = regWrEn && (regAddr == ADDR_W'(CTRL_ADDR));
  assign wrCfg    = regWrEn && (regAddr == ADDR_W'(CFG_ADDR));
  assign ackPulse = vecAck || (wrCtrl && ackWrBit);

  always_comb begin
    strobe        = '0;
    strobe.wrCtrl = wrCtrl;
    strobe.wrCfg  = wrCfg;
    // a freshly detected edge always sets, and wins over any clear
    strobe.latchSet = fallEdge;
    if (!modeBit) begin
      strobe.latchClr = ackPulse;
      strobe.holdClr  = 1'b1;
    end else begin
      // level mode: release needs acknowledge and a high line
      strobe.latchClr = pinSync && (ackPulse || ackHeld);
      strobe.holdSet  = ackPulse && !pinSync && !fallEdge;
      strobe.holdClr  = fallEdge || (ackHeld && pinSync);
    end
  end
endmodule

// File: rtl/pinIrqDatapath.sv
module pinIrqDatapath
  import pinIrqPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  pinIrqStrobes_t    strobe,
  output logic              fallEdge,
  output logic              pinSync,
  output logic              modeBit,
  output logic              ackHeld,
  output logic              flagQ,
  output logic              irqReq,
  output logic              pullUpDis,
  output logic [DATA_W-1:0] regRdData
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ;
  logic latchQ;
  logic holdQ;
  logic maskQ;
  logic modeQ;
  logic pullQ;
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData[DATA_W-1:2];

  // synchronizer resets low so a line held low through reset makes no edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], pinN};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign pinSync  = syncQ[SYNC_STAGES-1];
  assign fallEdge = prevQ && !pinSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= 1'b0;
      holdQ  <= 1'b0;
    end else begin
      if (strobe.latchSet)      latchQ <= 1'b1;
      else if (strobe.latchClr) latchQ <= 1'b0;
      if (strobe.holdClr)       holdQ  <= 1'b0;
      else if (strobe.holdSet)  holdQ  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= 1'b0;
      modeQ <= 1'b0;
      pullQ <= 1'b0;
    end else begin
      if (strobe.wrCtrl) begin
        maskQ <= regWrData[MASK_BIT];
        modeQ <= regWrData[MODE_BIT];
      end
      if (strobe.wrCfg) pullQ <= regWrData[PULL_BIT];
    end
  end

  assign modeBit   = modeQ;
  assign ackHeld   = holdQ;
  assign flagQ     = latchQ;
  assign irqReq    = latchQ && !maskQ;
  assign pullUpDis = pullQ;

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(CTRL_ADDR)) begin
      regRdData[MODE_BIT]  = modeQ;
      regRdData[MASK_BIT]  = maskQ;
      regRdData[FLAG_BIT]  = latchQ;
      regRdData[LEVEL_BIT] = pinSync;
    end else if (regAddr == ADDR_W'(CFG_ADDR)) begin
      regRdData[PULL_BIT]  = pullQ;
    end
  end

  assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    fallEdge |=> latchQ);
  assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ && latchQ && !pinSync) |=> latchQ);
  assert_level_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ && holdQ && pinSync) |=> !latchQ);
  assert_pull_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrCfg |=> $stable(pullQ));
endmodule

// File: rtl/pinIrqCtrl.sv
module pinIrqCtrl
  import pinIrqPkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          ADDR_W      = 1,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] VEC_ADDR    = 16'hFFFA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              vecAck,
  output logic              irqReq,
  output logic              pinLevel,
  output logic              pullUpDis,
  output logic [15:0]       vecAddr
);
  pinIrqStrobes_t strobe;
  logic fallEdge;
  logic pinSync;
  logic modeBit;
  logic ackHeld;
  logic flagQ;

  pinIrqControl #(.ADDR_W(ADDR_W)) uCtrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .ackWrBit (regWrData[ACK_BIT]),
    .vecAck   (vecAck),
    .fallEdge (fallEdge),
    .pinSync  (pinSync),
    .modeBit  (modeBit),
    .ackHeld  (ackHeld),
    .strobe   (strobe)
  );

  pinIrqDatapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .pinN      (pinN),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strobe    (strobe),
    .fallEdge  (fallEdge),
    .pinSync   (pinSync),
    .modeBit   (modeBit),
    .ackHeld   (ackHeld),
    .flagQ     (flagQ),
    .irqReq    (irqReq),
    .pullUpDis (pullUpDis),
    .regRdData (regRdData)
  );

  assign pinLevel = pinSync;
  assign vecAddr  = VEC_ADDR;

  assert_edge_ack_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!modeBit && vecAck && !fallEdge) |=> !flagQ);
  assert_ack_edge_keeps_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fallEdge && vecAck) |=> flagQ);
endmodule

// File: tb/pinIrqCtrl_test.sv
module pinIrqCtrl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pinN = 1'b1;
  logic [0:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       vecAck = 1'b0;
  logic       irqReq, pinLevel, pullUpDis;
  logic [15:0] vecAddr;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pinIrqCtrl uut (
    .clk(clk), .rstN(rstN), .pinN(pinN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .vecAck(vecAck), .irqReq(irqReq),
    .pinLevel(pinLevel), .pullUpDis(pullUpDis), .vecAddr(vecAddr)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readReg(input logic [0:0] a, output logic [7:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic writeReg(input logic [0:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick(1);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pulseAck();
    vecAck = 1'b1;
    tick(1);
    vecAck = 1'b0;
  endtask

  function automatic logic flagOf(input logic [7:0] s);
    return s[3];
  endfunction

  task automatic testReset();
    logic [7:0] d;
    tick(3);
    readReg(0, d); check("R1 status in reset", d, 8'h00);
    readReg(1, d); check("R1 config in reset", d, 8'h00);
    check("R1 irq in reset", irqReq, 0);
    check("R10 pull-up enabled by default", pullUpDis, 0);
    check("R12 vector address", vecAddr, 16'hFFFA);
    rstN = 1'b1;
    tick(1);
    check("R11 level not yet through", pinLevel, 0);
    tick(1);
    check("R11 level after two edges", pinLevel, 1);
    readReg(0, d); check("R1 R9 status after reset", d, 8'h10);
  endtask

  task automatic testEdgeMode();
    logic [7:0] d;
    pinN = 1'b0;
    tick(2);
    readReg(0, d); check("R2 flag not early", flagOf(d), 0);
    tick(1);
    readReg(0, d); check("R2 R9 flag on third edge", d, 8'h08);
    check("R2 irq raised", irqReq, 1);
    pulseAck();
    readReg(0, d); check("R3 vector ack clears", flagOf(d), 0);
    tick(4);
    readReg(0, d); check("R3 stays clear with line low", flagOf(d), 0);
    pinN = 1'b1; tick(3);
    pinN = 1'b0; tick(3);
    readReg(0, d); check("R6 new edge after ack latches", flagOf(d), 1);
    writeReg(0, 8'h00);
    readReg(0, d); check("R8 write zero to ack keeps flag", flagOf(d), 1);
    writeReg(0, 8'h04);
    readReg(0, d); check("R3 R8 software ack clears, ack reads zero", d, 8'h00);
    pinN = 1'b1; tick(3);
  endtask

  task automatic testMask();
    logic [7:0] d;
    writeReg(0, 8'h02);
    pinN = 1'b0; tick(3);
    readReg(0, d); check("R7 flag visible while masked", d, 8'h0A);
    check("R7 irq held off by mask", irqReq, 0);
    writeReg(0, 8'h00);
    check("R7 irq after unmask", irqReq, 1);
    pulseAck();
    check("R7 irq low after ack", irqReq, 0);
    pinN = 1'b1; tick(3);
  endtask

  task automatic testEdgeWins();
    logic [7:0] d;
    pinN = 1'b0; tick(3);
    pinN = 1'b1; tick(3);
    pinN = 1'b0; tick(2);
    pulseAck();
    readReg(0, d); check("R5 edge beats same-cycle ack", flagOf(d), 1);
    pulseAck();
    readReg(0, d); check("R3 later ack clears", flagOf(d), 0);
    pinN = 1'b1; tick(3);
  endtask

  task automatic testLevelAckFirst();
    logic [7:0] d;
    writeReg(0, 8'h01);
    pinN = 1'b0; tick(3);
    readReg(0, d); check("R4 level request set", d, 8'h09);
    pulseAck();
    tick(3);
    readReg(0, d); check("R4 ack with line low keeps request", flagOf(d), 1);
    pinN = 1'b1; tick(2);
    readReg(0, d); check("R4 not cleared before line sync", flagOf(d), 1);
    tick(1);
    readReg(0, d); check("R4 cleared on third edge after rise", d, 8'h11);
  endtask

  task automatic testLevelPinFirst();
    logic [7:0] d;
    pinN = 1'b0; tick(3);
    pinN = 1'b1; tick(4);
    readReg(0, d); check("R4 line high without ack keeps request", flagOf(d), 1);
    check("R4 irq still raised", irqReq, 1);
    writeReg(0, 8'h05);
    readReg(0, d); check("R4 ack after rise clears", d, 8'h11);
  endtask

  task automatic testResetLow();
    logic [7:0] d;
    pinN = 1'b0; tick(3);
    readReg(0, d); check("R13 request before reset", flagOf(d), 1);
    rstN = 1'b0; tick(2);
    rstN = 1'b1; tick(4);
    readReg(0, d); check("R13 reset clears latch and mode with line low", d, 8'h00);
    check("R13 irq low after reset", irqReq, 0);
    pinN = 1'b1; tick(3);
  endtask

  task automatic testConfig();
    logic [7:0] d;
    writeReg(1, 8'hFF);
    check("R10 pull-up disabled", pullUpDis, 1);
    readReg(1, d); check("R9 config layout", d, 8'h01);
    writeReg(0, 8'hFB);
    readReg(0, d); check("R9 read-only bits ignored", d, 8'h13);
    check("R7 no irq without request", irqReq, 0);
    writeReg(1, 8'h00);
    check("R10 pull-up enabled again", pullUpDis, 0);
    writeReg(0, 8'h00);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    testReset();
    testEdgeMode();
    testMask();
    testEdgeWins();
    testLevelAckFirst();
    testLevelPinFirst();
    testResetLow();
    testConfig();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule